// File: doc/BRIEF.md
# Fractional-Period Precision Time Clock

This block keeps a running time of day for precision time stamping: a 30-bit nanoseconds field that wraps at one billion and a 48-bit seconds field. Each reference clock cycle the time advances by a programmable period. The period is an exact rational number of nanoseconds: an integer quotient plus a numerator over a denominator. A fraction accumulator collects the numerator each cycle. Whenever it reaches the denominator, that cycle gains one extra nanosecond. A period of 2.5 ns is therefore quotient 2 with a numerator of half the denominator.

Software drives the block through a single-cycle register write port and a registered read port. Period values, set-time values and step values are written to staging registers. They reach the running clock only when a separate strobe address is written. A read of the current nanoseconds also freezes the current seconds in a snapshot, so the seconds read afterwards belong to the same instant. An event pulse latches the time and a 16-bit sequence id, and these stay readable until the next event.

Offsets larger than the step magnitude field are not handled by the step path. Software applies them by reading the time, adding the offset and loading the result with a set-time.

Top module: `ptp_frac_clock`

## Requirements
- R1: After reset the time is zero, the cycle period is 1 + 0/1 ns (the time advances by 1 ns per cycle), `cfg_err` is 0 and the event registers read 0.
- R2: Each cycle the fraction accumulator adds the active numerator. When the sum is at least the active denominator, the denominator is subtracted and that cycle advances by quotient + 1 ns; otherwise it advances by the quotient.
- R3: Writes to address 0 (quotient, bits 7:0), 1 (numerator) and 2 (denominator) are staged only. They change nothing until address 3 is written. That commit loads all three and clears the fraction accumulator; the commit cycle itself still uses the old period.
- R4: A commit with a staged denominator of 0, or a numerator not below the denominator, sets `cfg_err` and keeps the old period. A valid commit clears `cfg_err`.
- R5: Nanoseconds wrap at 1,000,000,000 and carry one into the 48-bit seconds, including the carry from the lower 32 bits into the upper 16.
- R6: Addresses 4 (nanoseconds, bits 29:0), 5 (upper seconds, bits 15:0) and 6 (lower seconds) are staged. A write to address 7 loads all three into the time at once. A staged nanoseconds value of 1e9 or more loads as 999,999,999.
- R7: Address 8 holds the step: bit 31 is the sign (1 = subtract) and bits 23:0 are the magnitude in ns. A write to address 9 adds or subtracts the magnitude, together with that cycle's normal increment.
- R8: A negative step that takes nanoseconds below zero borrows one second and leaves nanoseconds at the value plus 1e9.
- R9: A read of address 10 returns the nanoseconds one cycle later and, at the same edge, snapshots the seconds. Address 11 returns the snapshot's lower 32 bits and address 12 its upper 16 bits, zero-extended.
- R10: An `evt_pulse` latches the time present before that edge and `evt_seqid`. Address 13 returns the latched nanoseconds, 14 the lower seconds and 15 {sequence id, upper seconds}. All of these hold until the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Read address |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| evt_pulse | input | 1 | Time-stamp event |
| evt_seqid | input | 16 | Sequence id stored with the event |
| cfg_err | output | 1 | Last period commit was rejected |

## Verification
Integer periods separate the quotient path from the fraction path. Periods such as 2.5 ns and random rational periods show whether the extra nanosecond lands on the right cycles. Directed loads just below the nanosecond wrap, including a carry out of the lower seconds word, tell a correct carry apart from a carry that is dropped or lands late. Steps near zero tell a borrow apart from a bare wrap. Staged writes that are never committed, and commits that are rejected, show that the running period and time are left untouched. A randomized mix of commits, loads, steps, events and reads, compared with a reference model in the bench, exposes interactions between strobes and the per-cycle advance.

// File: rtl/ptpc_pkg.sv
package ptpc_pkg;
  localparam int NS_W   = 30;
  localparam int SECL_W = 32;
  localparam int SECH_W = 16;
  localparam int SEC_W  = SECL_W + SECH_W;
  localparam logic [NS_W-1:0] NS_PER_SEC = 30'd1000000000;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [NS_W-1:0]  ns;
  } ptp_time_t;

  typedef enum logic [3:0] {
    A_QUO = 4'd0, A_NUM = 4'd1, A_DEN = 4'd2, A_COMMIT = 4'd3,
    A_SNS = 4'd4, A_SHI = 4'd5, A_SLO = 4'd6, A_SYNC = 4'd7,
    A_STEP = 4'd8, A_STEP_GO = 4'd9, A_NOW_NS = 4'd10, A_SNAP_LO = 4'd11,
    A_SNAP_HI = 4'd12, A_EV_NS = 4'd13, A_EV_LO = 4'd14, A_EV_HI = 4'd15
  } reg_addr_e;

  // Adds a signed nanosecond delta (|delta| below one second) with one wrap.
  function automatic ptp_time_t time_add(ptp_time_t t, logic signed [33:0] delta);
    logic signed [33:0] s;
    logic signed [33:0] lim;
    logic signed [33:0] adj;
    ptp_time_t r;
    lim = $signed({4'b0, NS_PER_SEC});
    s   = $signed({4'b0, t.ns}) + delta;
    if (s >= lim) begin
      adj   = s - lim;
      r.sec = t.sec + 48'd1;
    end else if (s < 0) begin
      adj   = s + lim;
      r.sec = t.sec - 48'd1;
    end else begin
      adj   = s;
      r.sec = t.sec;
    end
    r.ns = adj[NS_W-1:0];
    return r;
  endfunction
endpackage

// File: rtl/ptpc_period.sv
module ptpc_period #(
  parameter int DW     = 32,
  parameter int QUO_W  = 8,
  parameter int FRAC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_quo,
  input  logic             wr_num,
  input  logic             wr_den,
  input  logic             commit,
  input  logic [DW-1:0]    wr_data,
  output logic [QUO_W:0]   inc,
  output logic             cfg_err
);
  logic [QUO_W-1:0]  stg_quo, act_quo;
  logic [FRAC_W-1:0] stg_num, act_num, stg_den, act_den, facc;

  // Returns {carry, remainder} of one fraction accumulation step.
  function automatic logic [FRAC_W:0] frac_next(logic [FRAC_W-1:0] acc,
                                               logic [FRAC_W-1:0] num,
                                               logic [FRAC_W-1:0] den);
    logic [FRAC_W:0] s;
    logic [FRAC_W:0] d;
    s = {1'b0, acc} + {1'b0, num};
    if (s >= {1'b0, den}) begin
      d = s - {1'b0, den};
      return {1'b1, d[FRAC_W-1:0]};
    end
    return {1'b0, s[FRAC_W-1:0]};
  endfunction

  logic [FRAC_W:0] fstep_w;
  logic            carry_w;
  logic            stg_bad_w;
  logic            commit_bad_w;

  assign fstep_w      = frac_next(facc, act_num, act_den);
  assign carry_w      = fstep_w[FRAC_W];
  assign inc          = {1'b0, act_quo} + {{QUO_W{1'b0}}, carry_w};
  assign stg_bad_w    = (stg_den == '0) || (stg_num >= stg_den);
  assign commit_bad_w = commit && stg_bad_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_quo <= QUO_W'(1);
      stg_num <= '0;
      stg_den <= FRAC_W'(1);
      act_quo <= QUO_W'(1);
      act_num <= '0;
      act_den <= FRAC_W'(1);
      facc    <= '0;
      cfg_err <= 1'b0;
    end else begin
      if (wr_quo) stg_quo <= wr_data[QUO_W-1:0];
      if (wr_num) stg_num <= wr_data[FRAC_W-1:0];
      if (wr_den) stg_den <= wr_data[FRAC_W-1:0];
      if (commit && !stg_bad_w) begin
        act_quo <= stg_quo;
        act_num <= stg_num;
        act_den <= stg_den;
        facc    <= '0;
        cfg_err <= 1'b0;
      end else begin
        facc <= fstep_w[FRAC_W-1:0];
        if (commit_bad_w) cfg_err <= 1'b1;
      end
    end
  end

  a_r4_den_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    act_den != '0);
  a_r2_frac_below_den: assert property (@(posedge clk) disable iff (!rst_n)
    facc < act_den);
  a_r4_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    commit_bad_w |=> cfg_err && act_den == $past(act_den) &&
                     act_num == $past(act_num) && act_quo == $past(act_quo));
  a_r3_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(act_quo) && $stable(act_num) && $stable(act_den));
endmodule

// File: rtl/ptpc_timer.sv
module ptpc_timer
  import ptpc_pkg::*;
#(
  parameter int DW     = 32,
  parameter int QUO_W  = 8,
  parameter int STEP_W = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [QUO_W:0] inc,
  input  logic           wr_sns,
  input  logic           wr_shi,
  input  logic           wr_slo,
  input  logic           sync,
  input  logic           wr_step,
  input  logic           step_go,
  input  logic [DW-1:0]  wr_data,
  output ptp_time_t      now,
  output logic           tick_wrap
);
  logic [NS_W-1:0]   stg_ns;
  logic [SECH_W-1:0] stg_shi;
  logic [SECL_W-1:0] stg_slo;
  logic              stg_neg;
  logic [STEP_W-1:0] stg_mag;

  logic signed [33:0] inc_s, mag_s, step_delta;
  ptp_time_t          tick_next, step_next;
  logic [NS_W-1:0]    sync_ns;
  logic               step_under_w;

  assign inc_s        = $signed(34'(inc));
  assign mag_s        = $signed(34'(stg_mag));
  assign step_delta   = stg_neg ? (inc_s - mag_s) : (inc_s + mag_s);
  assign tick_next    = time_add(now, inc_s);
  assign step_next    = time_add(now, step_delta);
  assign tick_wrap    = (tick_next.sec != now.sec);
  assign sync_ns      = (stg_ns >= NS_PER_SEC) ? (NS_PER_SEC - 30'd1) : stg_ns;
  assign step_under_w = stg_neg && (34'(stg_mag) > (34'(now.ns) + 34'(inc)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_ns  <= '0;
      stg_shi <= '0;
      stg_slo <= '0;
      stg_neg <= 1'b0;
      stg_mag <= '0;
      now     <= '0;
    end else begin
      if (wr_sns)  stg_ns  <= wr_data[NS_W-1:0];
      if (wr_shi)  stg_shi <= wr_data[SECH_W-1:0];
      if (wr_slo)  stg_slo <= wr_data[SECL_W-1:0];
      if (wr_step) begin
        stg_neg <= wr_data[DW-1];
        stg_mag <= wr_data[STEP_W-1:0];
      end
      if (sync)         now <= '{sec: {stg_shi, stg_slo}, ns: sync_ns};
      else if (step_go) now <= step_next;
      else              now <= tick_next;
    end
  end

  a_r5_ns_below_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    now.ns < NS_PER_SEC);
  a_r5_carry_second: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync && !step_go && tick_wrap) |=> now.sec == $past(now.sec) + 48'd1);
  a_r6_sync_seconds: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> now.sec == $past({stg_shi, stg_slo}));
  a_r8_borrow_second: assert property (@(posedge clk) disable iff (!rst_n)
    (step_go && !sync && step_under_w) |=> now.sec == $past(now.sec) - 48'd1);
endmodule

// File: rtl/ptpc_capture.sv
module ptpc_capture
  import ptpc_pkg::*;
#(
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic [SEQ_W-1:0] seqid,
  input  ptp_time_t        now,
  output ptp_time_t        cap_time,
  output logic [SEQ_W-1:0] cap_seq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_time <= '0;
      cap_seq  <= '0;
    end else if (evt) begin
      cap_time <= now;
      cap_seq  <= seqid;
    end
  end

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> $stable(cap_time) && $stable(cap_seq));
  a_r10_seq_taken: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> cap_seq == $past(seqid));
endmodule

// File: rtl/ptp_frac_clock.sv
module ptp_frac_clock
  import ptpc_pkg::*;
#(
  parameter int DW     = 32,
  parameter int AW     = 4,
  parameter int QUO_W  = 8,
  parameter int FRAC_W = 32,
  parameter int STEP_W = 24,
  parameter int SEQ_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data,
  input  logic             evt_pulse,
  input  logic [SEQ_W-1:0] evt_seqid,
  output logic             cfg_err
);
  function automatic logic hit(logic en, logic [AW-1:0] a, reg_addr_e r);
    return en && (a == AW'(r));
  endfunction

  logic [QUO_W:0]   inc;
  ptp_time_t        now, cap_time;
  logic [SEQ_W-1:0] cap_seq;
  logic [SEC_W-1:0] snap_sec;
  logic             tick_wrap;
  logic             rd_now_w;

  ptpc_period #(.DW(DW), .QUO_W(QUO_W), .FRAC_W(FRAC_W)) u_period (
    .clk(clk), .rst_n(rst_n),
    .wr_quo(hit(wr_en, wr_addr, A_QUO)),
    .wr_num(hit(wr_en, wr_addr, A_NUM)),
    .wr_den(hit(wr_en, wr_addr, A_DEN)),
    .commit(hit(wr_en, wr_addr, A_COMMIT)),
    .wr_data(wr_data), .inc(inc), .cfg_err(cfg_err)
  );

  ptpc_timer #(.DW(DW), .QUO_W(QUO_W), .STEP_W(STEP_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .inc(inc),
    .wr_sns(hit(wr_en, wr_addr, A_SNS)),
    .wr_shi(hit(wr_en, wr_addr, A_SHI)),
    .wr_slo(hit(wr_en, wr_addr, A_SLO)),
    .sync(hit(wr_en, wr_addr, A_SYNC)),
    .wr_step(hit(wr_en, wr_addr, A_STEP)),
    .step_go(hit(wr_en, wr_addr, A_STEP_GO)),
    .wr_data(wr_data), .now(now), .tick_wrap(tick_wrap)
  );

  ptpc_capture #(.SEQ_W(SEQ_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .evt(evt_pulse), .seqid(evt_seqid),
    .now(now), .cap_time(cap_time), .cap_seq(cap_seq)
  );

  assign rd_now_w = hit(rd_en, rd_addr, A_NOW_NS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      snap_sec <= '0;
    end else if (rd_en) begin
      if (rd_now_w) snap_sec <= now.sec;
      case (rd_addr)
        AW'(A_NOW_NS):  rd_data <= DW'(now.ns);
        AW'(A_SNAP_LO): rd_data <= DW'(snap_sec[SECL_W-1:0]);
        AW'(A_SNAP_HI): rd_data <= DW'(snap_sec[SEC_W-1:SECL_W]);
        AW'(A_EV_NS):   rd_data <= DW'(cap_time.ns);
        AW'(A_EV_LO):   rd_data <= DW'(cap_time.sec[SECL_W-1:0]);
        AW'(A_EV_HI):   rd_data <= DW'({cap_seq, cap_time.sec[SEC_W-1:SECL_W]});
        default:        rd_data <= '0;
      endcase
    end
  end

  a_r9_coherent_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    rd_now_w |=> snap_sec == $past(now.sec) && rd_data == DW'($past(now.ns)));
endmodule

// File: tb/ptp_frac_clock_tb.sv
module ptp_frac_clock_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, evt_pulse = 1'b0;
  logic [3:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [15:0] evt_seqid = '0;
  logic        cfg_err;

  always #4 clk = ~clk;

  ptp_frac_clock u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .evt_pulse(evt_pulse), .evt_seqid(evt_seqid), .cfg_err(cfg_err)
  );

  localparam longint BILLION = 64'd1000000000;
  localparam longint SEC_MASK = (64'd1 << 48) - 1;

  int errors = 0;
  int checks = 0;

  // reference model state
  longint m_ns = 0, m_sec = 0, m_facc = 0;
  longint m_quo = 1, m_num = 0, m_den = 1;
  longint s_quo = 1, s_num = 0, s_den = 1;
  longint s_ns = 0, s_shi = 0, s_slo = 0, s_mag = 0;
  bit     s_neg = 0, m_err = 0;
  longint snap = 0, c_ns = 0, c_sec = 0, c_seq = 0;
  longint exp_rd = 0;

  task automatic chk(input string tag, input longint got, input longint exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic void apply_delta(longint d);
    longint s;
    s = m_ns + d;
    if (s >= BILLION) begin m_ns = s - BILLION; m_sec = (m_sec + 1) & SEC_MASK; end
    else if (s < 0)   begin m_ns = s + BILLION; m_sec = (m_sec - 1) & SEC_MASK; end
    else m_ns = s;
  endfunction

  function automatic void model_step(bit we, int wa, longint wd, bit re, int ra, bit ev, longint sq);
    longint sum, fnew, inc;
    if (re) begin
      case (ra)
        10: begin exp_rd = m_ns; snap = m_sec; end
        11: exp_rd = snap & 64'hFFFF_FFFF;
        12: exp_rd = snap >> 32;
        13: exp_rd = c_ns;
        14: exp_rd = c_sec & 64'hFFFF_FFFF;
        15: exp_rd = (c_seq << 16) | (c_sec >> 32);
        default: exp_rd = 0;
      endcase
    end
    if (ev) begin c_ns = m_ns; c_sec = m_sec; c_seq = sq; end
    sum = m_facc + m_num;
    if (sum >= m_den) begin fnew = sum - m_den; inc = m_quo + 1; end
    else begin fnew = sum; inc = m_quo; end
    if (we) begin
      case (wa)
        0: s_quo = wd & 8'hFF;
        1: s_num = wd;
        2: s_den = wd;
        3: if (s_den == 0 || s_num >= s_den) m_err = 1;
           else begin m_quo = s_quo; m_num = s_num; m_den = s_den; fnew = 0; m_err = 0; end
        4: s_ns = wd & 32'h3FFF_FFFF;
        5: s_shi = wd & 16'hFFFF;
        6: s_slo = wd;
        8: begin s_neg = wd[31]; s_mag = wd & 32'h00FF_FFFF; end
        default: ;
      endcase
    end
    if (we && wa == 7) begin
      m_ns = (s_ns >= BILLION) ? BILLION - 1 : s_ns;
      m_sec = (s_shi << 32) | s_slo;
    end else if (we && wa == 9) apply_delta(s_neg ? inc - s_mag : inc + s_mag);
    else apply_delta(inc);
    m_facc = fnew;
  endfunction

  task automatic op(input bit we, input int wa, input longint wd, input bit re, input int ra,
                    input bit ev, input longint sq, input string tag);
    wr_en = we; wr_addr = 4'(wa); wr_data = 32'(wd);
    rd_en = re; rd_addr = 4'(ra); evt_pulse = ev; evt_seqid = 16'(sq);
    @(posedge clk);
    model_step(we, wa, wd, re, ra, ev, sq);
    @(negedge clk);
    wr_en = 0; rd_en = 0; evt_pulse = 0;
    if (re) chk(tag, longint'(rd_data), exp_rd);
    if (we && wa == 3) chk(tag, longint'(cfg_err), longint'(m_err));
  endtask

  task automatic wr(input int a, input longint d, input string tag);
    op(1, a, d, 0, 0, 0, 0, tag);
  endtask
  task automatic rd(input int a, input string tag);
    op(0, 0, 0, 1, a, 0, 0, tag);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) op(0, 0, 0, 0, 0, 0, 0, "idle");
  endtask
  task automatic set_time(input longint ns, input longint sec, input string tag);
    wr(4, ns, tag); wr(5, sec >> 32, tag); wr(6, sec & 64'hFFFF_FFFF, tag); wr(7, 0, tag);
  endtask
  task automatic read_time(input string tag);
    rd(10, tag); rd(11, tag); rd(12, tag);
  endtask
  task automatic period(input longint q, input longint n, input longint d, input string tag);
    wr(0, q, tag); wr(1, n, tag); wr(2, d, tag); wr(3, 0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    longint r;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 cfg_err", longint'(cfg_err), 0);
    rd(10, "R1 ns at reset");
    rd(13, "R1 event ns"); rd(15, "R1 event hi");
    idle(7);
    read_time("R1 default 1ns period");
    // R2: 2.5 ns period
    period(2, 500, 1000, "R2 commit");
    set_time(0, 0, "R2 load");
    idle(10);
    read_time("R2 2.5ns period");
    period(3, 1, 3, "R2 commit third");
    idle(13);
    read_time("R2 3+1/3 period");
    // R3: staged writes without commit
    wr(0, 9, "R3 stage"); wr(1, 7, "R3 stage"); wr(2, 11, "R3 stage");
    idle(5);
    read_time("R3 no commit");
    wr(3, 0, "R3 commit");
    idle(11);
    read_time("R3 after commit");
    // R4: rejected commits
    period(5, 0, 0, "R4 zero den");
    idle(4); read_time("R4 old period kept");
    period(5, 9, 9, "R4 num>=den");
    period(1, 0, 1, "R4 valid clears");
    // R5: wrap and carries
    set_time(999999995, 7, "R5 load");
    idle(8); read_time("R5 wrap");
    set_time(999999998, 64'h3_FFFF_FFFF, "R5 load lo carry");
    idle(4); read_time("R5 carry into upper seconds");
    // R6: staged set only on sync, clamp
    wr(4, 123, "R6 stage"); wr(5, 1, "R6 stage"); wr(6, 2, "R6 stage");
    idle(3); read_time("R6 no sync");
    wr(7, 0, "R6 sync"); read_time("R6 after sync");
    set_time(32'h3FFF_FFFF, 4, "R6 clamp"); read_time("R6 clamped");
    // R7: positive step
    set_time(1000, 50, "R7 load");
    wr(8, 12345, "R7 stage"); wr(9, 0, "R7 go"); read_time("R7 plus");
    wr(8, 32'h00FF_FFFF, "R7 stage max"); wr(9, 0, "R7 go max"); read_time("R7 plus max");
    // R8: negative step borrow
    set_time(3, 10, "R8 load");
    wr(8, 32'h8000_0064, "R8 stage"); wr(9, 0, "R8 go"); read_time("R8 borrow");
    // R9/R10: snapshot and event hold
    op(0, 0, 0, 0, 0, 1, 16'hBEEF, "R10 event");
    rd(13, "R10 ns"); rd(14, "R10 sec lo"); rd(15, "R10 seq/sec hi");
    idle(6);
    rd(13, "R10 held ns"); rd(15, "R10 held hi");
    rd(10, "R9 ns"); idle(3); rd(11, "R9 snap lo"); rd(12, "R9 snap hi");
    // random mix
    for (int i = 0; i < 600; i++) begin
      r = $urandom % 10;
      case (r)
        0: begin
          longint d, n;
          d = ($urandom % 8 == 0) ? 0 : 1 + $urandom % 2000;
          n = ($urandom % 8 == 0) ? d + $urandom % 5 : ((d == 0) ? 0 : $urandom % d);
          period($urandom % 4, n, d, "R4 random period");
        end
        1: set_time($urandom % 32'd1000000000,
                    ((longint'($urandom % 65536)) << 32) | $urandom, "R6 random load");
        2: begin
          wr(8, {($urandom % 2 == 1), 7'd0, 24'($urandom)}, "R7 random step");
          wr(9, 0, "R8 random step go");
          read_time("R7 random step");
        end
        3: op(0, 0, 0, 0, 0, 1, $urandom % 65536, "R10 random event");
        4, 5, 6: rd(10 + $urandom % 6, "R2 random read");
        default: idle(1 + $urandom % 20);
      endcase
    end
    read_time("R5 final");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule